// File: doc/BRIEF.md
# Parity-Checked Packet Discard Buffer

This block is a store-and-forward filter for a packetized AXI4-Stream completion path whose used data width is set at build time to 64, 128 or 256 bits. Every accepted beat carries one odd-parity bit per data byte and, on its final beat, an optional discontinue flag that marks a packet corrupted upstream. The buffer writes incoming beats behind a tentative pointer. It exposes a packet on its output only after the packet's last beat has arrived with no parity fault on any beat and no discontinue. A faulty packet is erased by rewinding the tentative pointer, so none of its beats ever reach the output.

Each erased packet raises a single-cycle pulse and advances a saturating drop counter. A packet longer than the buffer can never be committed. It is detected when its beats would overrun the buffer, swallowed up to its last beat, and counted as a drop. The input side then never stalls forever. Byte lanes above the configured width are ignored on the input and driven to zero on the output.

Top module: `parity_drop_buf`

## Requirements
- R1: While and right after reset, out_valid and drop_pulse are 0, drop_count is 0, and in_ready is 1.
- R2: A packet with no fault is output unchanged (data, keep, last, beat order). out_valid stays 0 for it until the clock edge that accepts its last beat, and becomes 1 right after that edge.
- R3: For each used byte lane i, the XOR of in_data[8i+7:8i] and in_parity[i] must be 1. A violation on any beat of a packet discards the whole packet.
- R4: in_discontinue, which is only raised together with in_last, discards the whole packet.
- R5: Each discarded packet sets drop_pulse for exactly the one cycle that follows the edge accepting its last beat. drop_count rises by one at that same edge and holds at all ones (0xFFFF at the default width).
- R6: Used lanes are the lowest BUS_W/8 bytes and the lowest BUS_W/32 keep bits. Parity faults in higher lanes are ignored. out_data above BUS_W and out_keep above BUS_W/32 are 0.
- R7: Once DEPTH beats are held, in_ready is 0 unless the held beats all belong to the packet still arriving. While out_valid is 1 and out_ready is 0, the output beat is held stable.
- R8: A packet of more than DEPTH beats is accepted in full, discarded and counted. A packet of exactly DEPTH beats still passes.
- R9: Discarded packets leave no gap or residue: good packets sent around them come out back to back, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Buffer can take a beat |
| in_data | input | 256 | Input beat data, lanes above BUS_W ignored |
| in_keep | input | 8 | Valid dword flags per beat |
| in_last | input | 1 | Final beat of a packet |
| in_parity | input | 32 | Odd parity bit per data byte |
| in_discontinue | input | 1 | Upstream error on the final beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 256 | Output beat data, upper lanes zero |
| out_keep | output | 8 | Output dword flags, upper bits zero |
| out_last | output | 1 | Final beat of an output packet |
| drop_pulse | output | 1 | One-cycle flag per discarded packet |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
The hardest state to reach is a packet that fills the whole buffer and then keeps coming. That is the only case in which the input must stay ready while the buffer is full. The bench reaches it by holding out_ready low on an empty buffer and sending a packet three beats longer than the depth, then one of exactly the depth. Counter saturation needs over 65535 discards. The bench produces them by holding a continuous stream of single-beat packets that carry discontinue, which is accepted at one packet per cycle.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    localparam int MAX_DW     = 256;
    localparam int MAX_LANES  = MAX_DW / 8;
    localparam int MAX_DWORDS = MAX_DW / 32;

    typedef struct packed {
        logic                  last;
        logic [MAX_DWORDS-1:0] keep;
        logic [MAX_DW-1:0]     data;
    } beat_t;

    typedef enum logic {
        WR_STORE = 1'b0,
        WR_SKIP  = 1'b1
    } wr_mode_e;

    function automatic logic [MAX_DW-1:0] data_mask(input int bus_w);
        logic [MAX_DW-1:0] m;
        for (int i = 0; i < MAX_DW; i++) m[i] = (i < bus_w);
        return m;
    endfunction

    function automatic logic [MAX_DWORDS-1:0] keep_mask(input int bus_w);
        logic [MAX_DWORDS-1:0] m;
        for (int i = 0; i < MAX_DWORDS; i++) m[i] = (i < bus_w / 32);
        return m;
    endfunction

    function automatic logic [MAX_LANES-1:0] lane_mask(input int bus_w);
        logic [MAX_LANES-1:0] m;
        for (int i = 0; i < MAX_LANES; i++) m[i] = (i < bus_w / 8);
        return m;
    endfunction

    // odd parity: byte bits plus parity bit must hold an odd number of ones
    function automatic logic lane_odd_ok(input logic [7:0] b, input logic p);
        return ^{b, p};
    endfunction

endpackage

// File: rtl/pdb_parity_chk.sv
module pdb_parity_chk
    import pdb_pkg::*;
#(
    parameter int BUS_W = 128
) (
    input  logic [MAX_DW-1:0]    data,
    input  logic [MAX_LANES-1:0] parity,
    output logic                 any_bad
);

    localparam logic [MAX_LANES-1:0] USED = lane_mask(BUS_W);

    logic [MAX_LANES-1:0] lane_bad;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        assign lane_bad[i] = !lane_odd_ok(data[8*i +: 8], parity[i]);
    end

    // R3 / R6: only configured lanes may flag a fault
    assign any_bad = |(lane_bad & USED);

endmodule

// File: rtl/pdb_wr_ctrl.sv
module pdb_wr_ctrl
    import pdb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             beat_err,
    input  logic [PW-1:0]    rd_ptr,
    output logic             in_ready,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [PW-1:0]    commit_ptr,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] drop_count
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0]    tent_q, base_q;
    wr_mode_e         mode_q;
    logic             bad_q;
    logic             pulse_q;
    logic [CNT_W-1:0] cnt_q;

    logic [PW-1:0] used, tent_len;
    logic          full, over_hit, acc, drop_now;

    always_comb begin
        used     = tent_q - rd_ptr;
        tent_len = tent_q - base_q;
        full     = (used == DEPTH_P);
        over_hit = (tent_len == DEPTH_P);
        in_ready = (mode_q == WR_SKIP) || !full || over_hit;
        acc      = in_valid && in_ready;
        wr_en    = acc && (mode_q == WR_STORE) && !over_hit;
        drop_now = acc && in_last &&
                   ((mode_q == WR_SKIP) || over_hit || bad_q || beat_err);
    end

    assign wr_addr    = tent_q[AW-1:0];
    assign commit_ptr = base_q;
    assign drop_pulse = pulse_q;
    assign drop_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tent_q  <= '0;
            base_q  <= '0;
            mode_q  <= WR_STORE;
            bad_q   <= 1'b0;
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            pulse_q <= drop_now;
            if (drop_now && cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
            if (acc) begin
                if (mode_q == WR_SKIP) begin
                    if (in_last) mode_q <= WR_STORE;
                end else if (over_hit) begin
                    tent_q <= base_q;
                    bad_q  <= 1'b0;
                    if (!in_last) mode_q <= WR_SKIP;
                end else if (in_last) begin
                    bad_q <= 1'b0;
                    if (bad_q || beat_err) begin
                        tent_q <= base_q;
                    end else begin
                        tent_q <= tent_q + 1'b1;
                        base_q <= tent_q + 1'b1;
                    end
                end else begin
                    tent_q <= tent_q + 1'b1;
                    bad_q  <= bad_q || beat_err;
                end
            end
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_P);

    assert_drop_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(in_valid && in_ready && in_last));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> pulse_q);

endmodule

// File: rtl/pdb_store.sv
module pdb_store
    import pdb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  beat_t         wr_beat,
    input  logic [PW-1:0] commit_ptr,
    input  logic          out_ready,
    output logic [PW-1:0] rd_ptr,
    output logic          out_valid,
    output beat_t         out_beat
);

    beat_t         mem_q [DEPTH];
    logic [PW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_beat;
    end

    assign out_valid = (rd_q != commit_ptr);
    assign out_beat  = mem_q[rd_q[AW-1:0]];
    assign rd_ptr    = rd_q;

    always_ff @(posedge clk) begin
        if (rst)                        rd_q <= '0;
        else if (out_valid && out_ready) rd_q <= rd_q + 1'b1;
    end

    assert_out_stable_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_beat));

endmodule

// File: rtl/parity_drop_buf.sv
module parity_drop_buf
    import pdb_pkg::*;
#(
    parameter int BUS_W = 128,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [MAX_DW-1:0]     in_data,
    input  logic [MAX_DWORDS-1:0] in_keep,
    input  logic                  in_last,
    input  logic [MAX_LANES-1:0]  in_parity,
    input  logic                  in_discontinue,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [MAX_DW-1:0]     out_data,
    output logic [MAX_DWORDS-1:0] out_keep,
    output logic                  out_last,
    output logic                  drop_pulse,
    output logic [CNT_W-1:0]      drop_count
);

    localparam logic [MAX_DW-1:0]     DMASK = data_mask(BUS_W);
    localparam logic [MAX_DWORDS-1:0] KMASK = keep_mask(BUS_W);

    logic          par_bad, beat_err, wr_en;
    logic [AW-1:0] wr_addr;
    logic [PW-1:0] commit_ptr, rd_ptr;
    beat_t         wr_beat, rd_beat;

    pdb_parity_chk #(.BUS_W(BUS_W)) u_par (
        .data    (in_data),
        .parity  (in_parity),
        .any_bad (par_bad)
    );

    assign beat_err = par_bad || (in_last && in_discontinue);

    always_comb begin
        wr_beat.data = in_data & DMASK;
        wr_beat.keep = in_keep & KMASK;
        wr_beat.last = in_last;
    end

    pdb_wr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .beat_err   (beat_err),
        .rd_ptr     (rd_ptr),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit_ptr (commit_ptr),
        .drop_pulse (drop_pulse),
        .drop_count (drop_count)
    );

    pdb_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_beat    (wr_beat),
        .commit_ptr (commit_ptr),
        .out_ready  (out_ready),
        .rd_ptr     (rd_ptr),
        .out_valid  (out_valid),
        .out_beat   (rd_beat)
    );

    assign out_data = rd_beat.data;
    assign out_keep = rd_beat.keep;
    assign out_last = rd_beat.last;

    assert_disc_on_last_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_discontinue |-> in_last);

    assert_fwd_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

    assert_drop_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |=> !drop_pulse || $past(in_valid && in_ready && in_last));

endmodule

// File: tb/parity_drop_buf_tb.sv
`timescale 1ns/1ps
module parity_drop_buf_tb;

    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0, in_last = 1'b0, in_discontinue = 1'b0;
    logic [255:0] in_data = '0;
    logic [7:0]   in_keep = '0;
    logic [31:0]  in_parity = '0;
    logic         out_ready = 1'b0;
    logic         in_ready, out_valid, out_last, drop_pulse;
    logic [255:0] out_data;
    logic [7:0]   out_keep;
    logic [15:0]  drop_count;

    int  n_chk = 0, n_fail = 0, exp_cnt = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    parity_drop_buf u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_keep(in_keep), .in_last(in_last), .in_parity(in_parity),
        .in_discontinue(in_discontinue),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    // table: nbeats, bad beat (255 = none), bad lane, discontinue, expect drop
    localparam logic [31:0] VEC [8] = '{
        {8'd1, 8'd255, 8'd0,  4'd0, 4'd0},
        {8'd3, 8'd255, 8'd0,  4'd0, 4'd0},
        {8'd3, 8'd1,   8'd5,  4'd0, 4'd1},
        {8'd2, 8'd255, 8'd0,  4'd1, 4'd1},
        {8'd2, 8'd0,   8'd20, 4'd0, 4'd0},
        {8'd4, 8'd3,   8'd15, 4'd0, 4'd1},
        {8'd1, 8'd255, 8'd0,  4'd1, 4'd1},
        {8'd5, 8'd255, 8'd0,  4'd0, 4'd0}
    };

    function automatic string vec_tag(input int e);
        case (e)
            2, 5:    return "R3";
            3, 6:    return "R4";
            4:       return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [255:0] gen_data(input int p, input int k);
        logic [255:0] d;
        for (int b = 0; b < 32; b++) d[8*b +: 8] = 8'(p*37 + k*11 + b*3 + 1);
        return d;
    endfunction

    function automatic logic [31:0] gen_par(input logic [255:0] d);
        logic [31:0] q;
        for (int b = 0; b < 32; b++) q[b] = ~^d[8*b +: 8];
        return q;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int p, input int nb, input int bad_beat,
                            input int bad_lane, input bit disc, input bit hold_chk);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            if (hold_chk && k > 0)
                check(out_valid == 1'b0, "R2", "out_valid before last beat",
                      256'(out_valid), 256'(0));
            in_data   = gen_data(p, k);
            in_parity = gen_par(in_data);
            if (k == bad_beat) in_parity[bad_lane] = ~in_parity[bad_lane];
            in_keep   = (k == nb - 1) ? 8'hF3 : 8'hFF;
            in_last   = (k == nb - 1);
            in_discontinue = disc && (k == nb - 1);
            in_valid  = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_discontinue = 1'b0;
    endtask

    // called at the negedge right after the last beat was taken
    task automatic check_drop(input bit exp_drop, input string req);
        check(drop_pulse == exp_drop, req, "drop_pulse", 256'(drop_pulse), 256'(exp_drop));
        if (exp_drop && exp_cnt < 65535) exp_cnt++;
        check(drop_count == 16'(exp_cnt), "R5", "drop_count", 256'(drop_count), 256'(exp_cnt));
    endtask

    task automatic drain_pkt(input int p, input int nb, input string req);
        for (int k = 0; k < nb; k++) begin
            logic [255:0] ed;
            logic [7:0]   ek;
            @(negedge clk);
            out_ready = 1'b1;
            ed = {128'b0, gen_data(p, k)[127:0]};
            ek = (k == nb - 1) ? 8'h03 : 8'h0F;
            check(out_valid == 1'b1, req, "out_valid", 256'(out_valid), 256'(1));
            check(out_data == ed, req, "out_data (R6 upper lanes zero)", out_data, ed);
            check({out_keep, out_last} == {ek, 1'(k == nb - 1)}, req, "keep/last",
                  256'({out_keep, out_last}), 256'({ek, 1'(k == nb - 1)}));
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [255:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && drop_pulse == 0 && drop_count == 0 && in_ready == 1,
              "R1", "reset state", 256'({out_valid, drop_pulse, drop_count, in_ready}),
              256'({1'b0, 1'b0, 16'd0, 1'b1}));
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && in_ready == 1, "R1", "after reset",
              256'({out_valid, in_ready}), 256'({1'b0, 1'b1}));

        // table walk
        for (int e = 0; e < 8; e++) begin
            int nb, bb, bl;
            bit ds, xd;
            nb = int'(VEC[e][31:24]); bb = int'(VEC[e][23:16]);
            bl = int'(VEC[e][15:8]);  ds = VEC[e][4]; xd = VEC[e][0];
            send_pkt(e, nb, (bb == 255) ? -1 : bb, bl, ds, 1'b1);
            check_drop(xd, vec_tag(e));
            check(out_valid == !xd, vec_tag(e), "out_valid after last beat",
                  256'(out_valid), 256'(!xd));
            if (!xd) drain_pulse_and_data(e, nb, vec_tag(e));
            else begin
                @(negedge clk);
                check(drop_pulse == 0, "R5", "pulse one cycle", 256'(drop_pulse), 256'(0));
            end
        end

        // R7: fill with single-beat packets under backpressure
        for (int p = 100; p < 100 + DEPTH; p++) begin
            send_pkt(p, 1, -1, 0, 1'b0, 1'b0);
        end
        check(in_ready == 0, "R7", "in_ready when full", 256'(in_ready), 256'(0));
        held = out_data;
        repeat (3) @(negedge clk);
        check(out_valid == 1 && out_data == held, "R7", "held output stable", out_data, held);
        for (int p = 100; p < 100 + DEPTH; p++) drain_pkt(p, 1, "R9");
        check(out_valid == 0, "R9", "empty after drain", 256'(out_valid), 256'(0));

        // R9: bad packet between two good ones
        send_pkt(120, 1, -1, 0, 1'b0, 1'b0);
        send_pkt(121, 2, 0, 0, 1'b0, 1'b0);
        check_drop(1'b1, "R9");
        send_pkt(122, 2, -1, 0, 1'b0, 1'b0);
        drain_pkt(120, 1, "R9");
        drain_pkt(122, 2, "R9");
        check(out_valid == 0, "R9", "no residue", 256'(out_valid), 256'(0));

        // R8: oversize then exact-depth packet
        send_pkt(130, DEPTH + 3, -1, 0, 1'b0, 1'b0);
        check_drop(1'b1, "R8");
        check(out_valid == 0, "R8", "oversize not output", 256'(out_valid), 256'(0));
        send_pkt(131, DEPTH, -1, 0, 1'b0, 1'b0);
        check_drop(1'b0, "R8");
        drain_pkt(131, DEPTH, "R8");

        // R5: saturation with back-to-back discarded single-beat packets
        @(negedge clk);
        in_data = gen_data(140, 0); in_parity = gen_par(in_data); in_keep = 8'hFF;
        in_last = 1'b1; in_discontinue = 1'b1; in_valid = 1'b1;
        repeat (65540) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_discontinue = 1'b0;
        @(negedge clk);
        check(drop_count == 16'hFFFF, "R5", "counter saturates",
              256'(drop_count), 256'(16'hFFFF));
        check(out_valid == 0, "R4", "discarded stream not output", 256'(out_valid), 256'(0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic drain_pulse_and_data(input int p, input int nb, input string req);
        drain_pkt(p, nb, req);
        check(drop_pulse == 0 && out_valid == 0, req, "idle after packet",
              256'({drop_pulse, out_valid}), 256'(0));
    endtask

endmodule